// File: doc/BRIEF.md
# Halt Exit Recovery Sequencer

This block sits between a small processor core and its external bus pins. It takes over the bus while the core is halted or in any other low-power state. When the core wakes up, it keeps the pins in a safe forced state for a fixed settling delay. It then stretches the next memory access with a burst of extra wait states so that slow memories have time to respond. After that one access it steps aside, and the normal programmable wait-state generator is in charge again.

There are two phases. In the forced phase, the address and data bus output enables are dropped, which puts those buses in high impedance. The active-low strobes (read, write, memory request, I/O request, opcode fetch, refresh) are held inactive high. The memory-write strobe and the channel A serial transmit output are overridden only when their own control bits ask for it. No clock output passes through this block, so any free-running clock pin is left alone.

The forced phase covers the whole low-power period and a counted delay after wake-up. The burst phase begins at the first memory access that starts after the forced state is released. The feature is off unless the enable bit is 1 and the override-off bit is 0. When it is off, the block passes the core's strobes through and adds no delay at all.

Top module: `halt_wake_seq`

## Requirements
- R1: While rst is high and after it is released, with no low-power request, forced_o=0, xwait_o=0, every pin_strb_n_o bit is 1, and addr_oe_o, data_oe_o and txa_oe_o are 1.
- R2: The feature is active when rec_en_i=1 and rec_off_i=0. If lowpwr_i=1 is sampled while active, forced_o is 1 after that same clock edge. lowpwr_i stands for any of the halt, sleep, idle or standby states, and all of them are treated the same.
- R3: If rec_en_i=0 or rec_off_i=1, forced_o and xwait_o stay 0 whatever lowpwr_i and mem_start_i do.
- R4: Take the first edge at which lowpwr_i is sampled 0 after forced_o has been held by low-power. forced_o stays 1 after that edge and after each of the next 15 edges, which makes 16 cycles. It falls after the 17th edge. If lowpwr_i returns to 1 during this count, the count starts over at the next wake-up.
- R5: In every cycle with forced_o=1, all six pin_strb_n_o bits are 1, and addr_oe_o and data_oe_o are 0. The bits are: bit 0 read, bit 1 write, bit 2 memory request, bit 3 I/O request, bit 4 opcode fetch, bit 5 refresh.
- R6: In a forced cycle, pin_mwr_n_o is 1 if mwr_fn_en_i was 1. If mwr_fn_en_i was 0, pin_mwr_n_o follows core_mwr_n_i.
- R7: In a forced cycle, txa_oe_o is 0 if txa_hiz_en_i was 1, and it is 1 otherwise.
- R8: After release, the first mem_start_i pulse sampled at edge j drives xwait_o to 1 after edges j through j+7, which is 8 cycles. xwait_o is 0 after edge j+8.
- R9: After that burst, further mem_start_i pulses add no wait (xwait_o=0) until the next low-power episode.
- R10: Outside the forced state, pin_strb_n_o and pin_mwr_n_o equal the core inputs sampled at the previous edge. txa_oe_o, addr_oe_o and data_oe_o are 1.
- R11: If lowpwr_i=1 arrives while an access is still pending or a burst is running, the burst is abandoned and forced_o goes back to 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr_i | input | 1 | Core is in a halt or low-power state |
| rec_en_i | input | 1 | Recovery feature enable |
| rec_off_i | input | 1 | Override that disables recovery |
| txa_hiz_en_i | input | 1 | Tri-state the channel A transmit output while forced |
| mwr_fn_en_i | input | 1 | Memory-write strobe function is enabled |
| mem_start_i | input | 1 | One-cycle pulse at the start of a memory access |
| core_strb_n_i | input | 6 | Core active-low strobes (read, write, mreq, iorq, fetch, refresh) |
| core_mwr_n_i | input | 1 | Core memory-write strobe |
| pin_strb_n_o | output | 6 | Strobes to the pins |
| pin_mwr_n_o | output | 1 | Memory-write strobe to the pin |
| addr_oe_o | output | 1 | Address bus output enable |
| data_oe_o | output | 1 | Data bus output enable |
| txa_oe_o | output | 1 | Channel A transmit output enable |
| forced_o | output | 1 | Forced pin state is in effect |
| xwait_o | output | 1 | Extra wait request for the recovery burst |

## Verification
A settle counter that is off by one shows up at once. The forced_o falling edge moves one cycle away from the seventeenth edge after wake-up, and the strobes go back to following the core one cycle early or late. A burst-phase fault shows on xwait_o in the next access: the burst is seven or nine cycles long, it starts before any access has been requested, or it appears again on the second access. A fault in the mode gate shows within one cycle of a low-power request, because forced_o rises when recovery is disabled or stays low when it is enabled.

// File: rtl/halt_rec_pkg.sv
package halt_rec_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_ARMED  = 3'd3,
    ST_BURST  = 3'd4
  } rec_state_t;

  localparam int unsigned NUM_STRB = 6;

endpackage

// File: rtl/halt_rec_gate.sv
module halt_rec_gate (
  input  logic en_i,
  input  logic off_i,
  output logic active_o
);
  // Recovery runs only when enabled and not overridden off.
  always_comb active_o = en_i & ~off_i;
endmodule

// File: rtl/halt_rec_seq.sv
module halt_rec_seq
  import halt_rec_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned BURST_WAITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic lowpwr_i,
  input  logic mem_start_i,
  output logic force_nx_o,
  output logic forced_o,
  output logic xwait_o
);
  localparam int unsigned SW = (SETTLE_CYC  > 1) ? $clog2(SETTLE_CYC)  : 1;
  localparam int unsigned BW = (BURST_WAITS > 1) ? $clog2(BURST_WAITS) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYC - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BURST_WAITS - 1);

  rec_state_t st_q, st_nx;
  logic [SW-1:0] scnt_q, scnt_nx;
  logic [BW-1:0] bcnt_q, bcnt_nx;

  always_comb begin
    st_nx   = st_q;
    scnt_nx = scnt_q;
    bcnt_nx = bcnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (active_i && lowpwr_i) st_nx = ST_HOLD;
      end
      ST_HOLD: begin
        if (!active_i) st_nx = ST_RUN;
        else if (!lowpwr_i) begin
          st_nx   = ST_SETTLE;
          scnt_nx = '0;
        end
      end
      ST_SETTLE: begin
        if (!active_i) st_nx = ST_RUN;
        else if (lowpwr_i) st_nx = ST_HOLD;
        else if (scnt_q == S_LAST) st_nx = ST_ARMED;
        else scnt_nx = scnt_q + 1'b1;
      end
      ST_ARMED: begin
        if (!active_i) st_nx = ST_RUN;
        else if (lowpwr_i) st_nx = ST_HOLD;
        else if (mem_start_i) begin
          st_nx   = ST_BURST;
          bcnt_nx = '0;
        end
      end
      ST_BURST: begin
        if (!active_i) st_nx = ST_RUN;
        else if (lowpwr_i) st_nx = ST_HOLD;
        else if (bcnt_q == B_LAST) st_nx = ST_RUN;
        else bcnt_nx = bcnt_q + 1'b1;
      end
      default: st_nx = ST_RUN;
    endcase
  end

  always_comb force_nx_o = (st_nx == ST_HOLD) || (st_nx == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      scnt_q   <= '0;
      bcnt_q   <= '0;
      forced_o <= 1'b0;
      xwait_o  <= 1'b0;
    end else begin
      st_q     <= st_nx;
      scnt_q   <= scnt_nx;
      bcnt_q   <= bcnt_nx;
      forced_o <= force_nx_o;
      xwait_o  <= (st_nx == ST_BURST);
    end
  end

  // Independent run-length counters used only by the checks below.
  localparam int unsigned CW = $clog2(SETTLE_CYC + BURST_WAITS + 4) + 1;
  logic [CW-1:0] awake_run, xw_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      awake_run <= '0;
      xw_run    <= '0;
    end else begin
      awake_run <= lowpwr_i ? '0 : ((&awake_run) ? awake_run : awake_run + 1'b1);
      xw_run    <= xwait_o ? ((&xw_run) ? xw_run : xw_run + 1'b1) : '0;
    end
  end

  p_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (active_i && lowpwr_i) |=> forced_o);

  p_off_r3: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (!forced_o && !xwait_o));

  p_settle_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(forced_o) && $past(active_i)) |-> (awake_run == CW'(SETTLE_CYC + 1)));

  p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(xwait_o) && $past(active_i) && !$past(lowpwr_i)) |-> (xw_run == CW'(BURST_WAITS)));

  p_burst_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(xwait_o) |-> $past(mem_start_i));

  p_wake_cancel_r11: assert property (@(posedge clk) disable iff (rst)
    (active_i && lowpwr_i) |=> !xwait_o);

endmodule

// File: rtl/halt_rec_pinmux.sv
module halt_rec_pinmux
  import halt_rec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                force_nx_i,
  input  logic                txa_hiz_en_i,
  input  logic                mwr_fn_en_i,
  input  logic [NUM_STRB-1:0] core_strb_n_i,
  input  logic                core_mwr_n_i,
  output logic [NUM_STRB-1:0] pin_strb_n_o,
  output logic                pin_mwr_n_o,
  output logic                addr_oe_o,
  output logic                data_oe_o,
  output logic                txa_oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_mwr_n_o <= 1'b1;
      addr_oe_o   <= 1'b1;
      data_oe_o   <= 1'b1;
      txa_oe_o    <= 1'b1;
    end else begin
      pin_mwr_n_o <= (force_nx_i && mwr_fn_en_i) ? 1'b1 : core_mwr_n_i;
      addr_oe_o   <= ~force_nx_i;
      data_oe_o   <= ~force_nx_i;
      txa_oe_o    <= ~(force_nx_i && txa_hiz_en_i);
    end
  end

  for (genvar g = 0; g < NUM_STRB; g++) begin : g_strb
    always_ff @(posedge clk) begin
      if (rst) pin_strb_n_o[g] <= 1'b1;
      else     pin_strb_n_o[g] <= force_nx_i | core_strb_n_i[g];
    end
  end

  p_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(force_nx_i)) |-> (pin_strb_n_o == $past(core_strb_n_i)));

  p_txa_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_nx_i) && $past(txa_hiz_en_i)) |-> !txa_oe_o);

endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import halt_rec_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned BURST_WAITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lowpwr_i,
  input  logic                rec_en_i,
  input  logic                rec_off_i,
  input  logic                txa_hiz_en_i,
  input  logic                mwr_fn_en_i,
  input  logic                mem_start_i,
  input  logic [NUM_STRB-1:0] core_strb_n_i,
  input  logic                core_mwr_n_i,
  output logic [NUM_STRB-1:0] pin_strb_n_o,
  output logic                pin_mwr_n_o,
  output logic                addr_oe_o,
  output logic                data_oe_o,
  output logic                txa_oe_o,
  output logic                forced_o,
  output logic                xwait_o
);
  logic active, force_nx;

  halt_rec_gate u_gate (
    .en_i     (rec_en_i),
    .off_i    (rec_off_i),
    .active_o (active)
  );

  halt_rec_seq #(
    .SETTLE_CYC  (SETTLE_CYC),
    .BURST_WAITS (BURST_WAITS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .active_i    (active),
    .lowpwr_i    (lowpwr_i),
    .mem_start_i (mem_start_i),
    .force_nx_o  (force_nx),
    .forced_o    (forced_o),
    .xwait_o     (xwait_o)
  );

  halt_rec_pinmux u_pins (
    .clk           (clk),
    .rst           (rst),
    .force_nx_i    (force_nx),
    .txa_hiz_en_i  (txa_hiz_en_i),
    .mwr_fn_en_i   (mwr_fn_en_i),
    .core_strb_n_i (core_strb_n_i),
    .core_mwr_n_i  (core_mwr_n_i),
    .pin_strb_n_o  (pin_strb_n_o),
    .pin_mwr_n_o   (pin_mwr_n_o),
    .addr_oe_o     (addr_oe_o),
    .data_oe_o     (data_oe_o),
    .txa_oe_o      (txa_oe_o)
  );

  p_forced_pins_r5: assert property (@(posedge clk) disable iff (rst)
    forced_o |-> ((&pin_strb_n_o) && !addr_oe_o && !data_oe_o));

endmodule

// File: tb/sim_halt_wake_seq.sv
module sim_halt_wake_seq;
  localparam int SETTLE = 16;
  localparam int WAITS  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lowpwr = 0, en = 0, off = 0, txh = 0, mwf = 0, mst = 0;
  logic [5:0] cstrb = 6'h3f;
  logic cmwr = 1'b1;
  logic [5:0] pstrb;
  logic pmwr, aoe, doe, toe, frc, xw;

  int nvec = 0, nbad = 0;
  logic [5:0] pat = 6'h05;

  always #5 clk = ~clk;

  halt_wake_seq #(.SETTLE_CYC(SETTLE), .BURST_WAITS(WAITS)) u0 (
    .clk(clk), .rst(rst), .lowpwr_i(lowpwr), .rec_en_i(en), .rec_off_i(off),
    .txa_hiz_en_i(txh), .mwr_fn_en_i(mwf), .mem_start_i(mst),
    .core_strb_n_i(cstrb), .core_mwr_n_i(cmwr),
    .pin_strb_n_o(pstrb), .pin_mwr_n_o(pmwr), .addr_oe_o(aoe), .data_oe_o(doe),
    .txa_oe_o(toe), .forced_o(frc), .xwait_o(xw));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: drive a fresh strobe pattern, step, check all outputs.
  task automatic cyc(input logic ef, input logic ew, input string req);
    logic [5:0] p;
    p = pat;
    pat = pat + 6'd13;
    cstrb = p;
    cmwr = p[0];
    @(posedge clk); #1;
    chk({req, " forced"}, 32'(frc), 32'(ef));
    chk({req, " xwait"}, 32'(xw), 32'(ew));
    if (ef) begin
      chk("R5 strobes", 32'(pstrb), 32'h3f);
      chk("R5 oe", {30'd0, aoe, doe}, 32'd0);
      chk("R6 mwr", 32'(pmwr), 32'(mwf ? 1'b1 : p[0]));
      chk("R7 txa_oe", 32'(toe), 32'(!txh));
    end else begin
      chk("R10 strobes", 32'(pstrb), 32'(p));
      chk("R10 mwr", 32'(pmwr), 32'(p[0]));
      chk("R10 oe", {29'd0, aoe, doe, toe}, 32'd7);
    end
  endtask

  task automatic burst_then_second(input string req);
    mst = 1; cyc(0, 1, "R8 burst start"); mst = 0;
    for (int i = 1; i < WAITS; i++) cyc(0, 1, "R8 burst");
    cyc(0, 0, "R8 burst end");
    mst = 1; cyc(0, 0, "R9 second access"); mst = 0;
    for (int i = 0; i < 10; i++) cyc(0, 0, req);
  endtask

  task automatic episode(input int hold, input logic tx, input logic mw);
    txh = tx; mwf = mw;
    lowpwr = 1;
    for (int i = 0; i < hold; i++) cyc(1, 0, "R2 halted");
    lowpwr = 0;
    for (int i = 0; i < SETTLE; i++) cyc(1, 0, "R4 settle");
    cyc(0, 0, "R4 release");
    for (int i = 0; i < 3; i++) cyc(0, 0, "R8 armed no access");
    burst_then_second("R9 normal waits");
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        lowpwr = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset forced", 32'(frc), 0);
        chk("R1 reset xwait", 32'(xw), 0);
        chk("R1 reset strobes", 32'(pstrb), 32'h3f);
        chk("R1 reset oe", {29'd0, aoe, doe, toe}, 32'd7);
        lowpwr = 0;
        rst = 0;
        cyc(0, 0, "R1 idle");

        en = 1; off = 0;
        for (int m = 0; m < 4; m++) episode(1 + m * 2, m[0], m[1]);

        // Wake, then sleep again mid-settle: count restarts.
        txh = 0; mwf = 1;
        lowpwr = 1; cyc(1, 0, "R2 halted");
        lowpwr = 0;
        for (int i = 0; i < 5; i++) cyc(1, 0, "R4 partial settle");
        lowpwr = 1;
        for (int i = 0; i < 3; i++) cyc(1, 0, "R4 re-halt");
        lowpwr = 0;
        for (int i = 0; i < SETTLE; i++) cyc(1, 0, "R4 settle restart");
        cyc(0, 0, "R4 release restart");

        // Sleep again while armed, then while bursting.
        lowpwr = 1; cyc(1, 0, "R11 halt while armed");
        lowpwr = 0;
        for (int i = 0; i < SETTLE; i++) cyc(1, 0, "R4 settle");
        cyc(0, 0, "R4 release");
        mst = 1; cyc(0, 1, "R8 burst start"); mst = 0;
        cyc(0, 1, "R8 burst"); cyc(0, 1, "R8 burst");
        lowpwr = 1; cyc(1, 0, "R11 halt mid-burst");
        lowpwr = 0;
        for (int i = 0; i < SETTLE; i++) cyc(1, 0, "R4 settle");
        cyc(0, 0, "R4 release");
        burst_then_second("R11 fresh burst then normal");

        // Disabled by override bit, then by enable bit.
        for (int d = 0; d < 2; d++) begin
          en = (d == 1) ? 1'b0 : 1'b1;
          off = (d == 0);
          lowpwr = 1;
          for (int i = 0; i < 4; i++) cyc(0, 0, "R3 disabled halt");
          lowpwr = 0;
          for (int i = 0; i < 3; i++) cyc(0, 0, "R3 disabled wake");
          mst = 1; cyc(0, 0, "R3 disabled access"); mst = 0;
          for (int i = 0; i < WAITS + 2; i++) cyc(0, 0, "R3 no burst");
        end

        // Disable mid-halt releases at once.
        en = 1; off = 0;
        lowpwr = 1; cyc(1, 0, "R2 halted");
        off = 1; cyc(0, 0, "R3 override mid-halt");
        off = 0; lowpwr = 0;
        cyc(0, 0, "R3 no resume");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule